// File: doc/BRIEF.md
# SPI Controller Status Flags

This block is a byte-wide SPI controller that runs either as the clock-driving master or as a selected slave. It has one transmit holding byte, one receive holding byte and a receive shifter. Software sees four registers on a small CPU register bus: a transmit data port, a receive data port, an interrupt-flag register and an enable register for the two interrupt requests. The core of the block is the flag logic. It tracks transmit-empty, receive-full, overrun and a status bit whose meaning depends on the mode. It also detects overrun and runs the recovery sequence.

A received byte moves to the receive holding byte only while that byte is free. If the holding byte is still unread, the next byte stays parked in the shifter. An overrun is declared only when the first bit of yet another byte is sampled over that parked byte. Software recovers by acknowledging the overrun flag and reading the receive port twice, and it may do these two steps in either order. In master mode the serial clock is the system clock divided by a parameter (4 by default). In slave mode the serial clock, the select and the data input pass through synchronizers.

Top module: `spi_flag_ctrl`

## Requirements
- R1: The flag register (address 2) is laid out as bit 3 status, bit 2 overrun, bit 1 receive-full and bit 0 transmit-empty. Bits 7..4 always read 0. After reset, in master mode, the whole register reads 0x00.
- R2: In master mode, bit 3 reads 1 from the start of a transfer until its eighth bit has ended, and reads 0 when idle.
- R3: Transmit-empty becomes 1 when the transmit byte is loaded into the shifter. A write to the transmit port (address 0) clears it to 0.
- R4: When a finished byte is copied into the free receive holding byte, receive-full becomes 1. If enable bit 0 (address 3) is 1, irq_rx_full pulses for one cycle.
- R5: While receive-full is 1, a finished byte stays in the shifter. A read of the receive port (address 1) returns the holding byte. If a byte is parked, that read also moves the parked byte in and sets receive-full again, with a request as in R4. Otherwise the read clears receive-full.
- R6: If the first bit of a byte is sampled while a byte is parked, overrun becomes 1. If enable bit 1 is 1, irq_rx_err pulses for one cycle.
- R7: Writing 1 to flag bit 2, 1 or 0 clears that bit. Writing 0 to any of them leaves it unchanged.
- R8: Overrun recovery is one write of 0x04 to the flag register plus two reads of the receive port. The two reads return the older held byte and then the newest complete byte. The write and the reads may come in either order. Afterwards bits 2 and 1 read 0.
- R9: In slave mode, bit 3 reads the synchronized select level: 1 when not selected, 0 when selected.
- R10: Serial timing is clock-low idle, MSB first, sampled on the rising edge and shifted on the falling edge, 8 bits per byte. In master mode, consecutive rising edges of sclk_out are 4 system clocks apart.
- R11: In slave mode, dropping select in the middle of a byte discards the partial bits. The next selected byte is received whole.
- R12: Address 3 reads back the two enable bits written to it. Address 1 reads the receive holding byte. reg_rdata is 0 whenever reg_rd is low.
- R13: With both enables 0, receive-full and overrun still set, but no request pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = master, 0 = slave |
| reg_addr | input | 2 | Register address (0 TX, 1 RX, 2 flags, 3 enables) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| sclk_in | input | 1 | Serial clock from the master (slave mode) |
| sel_n_in | input | 1 | Active-low slave select (slave mode) |
| sdi | input | 1 | Serial data into the block |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out of the block |
| irq_rx_full | output | 1 | One-cycle receive-full request |
| irq_rx_err | output | 1 | One-cycle overrun request |

## Verification
The assertions assume that mode_master does not change while a master transfer is running. They also assume software never acknowledges transmit-empty or writes the transmit port in the same cycle the shifter loads. Finally, they assume that in slave mode each level of sclk_in and sel_n_in lasts longer than the synchronizer depth, so every edge is seen once. The stimulus holds each slave-side serial level for eight system clocks, switches mode only between transfers, and issues one register access at a time, spaced by an idle cycle.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam logic [1:0] A_TXD  = 2'd0;
  localparam logic [1:0] A_RXD  = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_IEN  = 2'd3;

  localparam int FB_TXE  = 0;
  localparam int FB_RXF  = 1;
  localparam int FB_OVR  = 2;
  localparam int FB_STAT = 3;

  localparam int IEN_W   = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_n;
    if (s == 0) begin : g_first
      always_comb stg_n = d;
    end else begin : g_rest
      always_comb stg_n = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_n;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DW      = 8,
  parameter int CLK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          sdi_m,
  input  logic          sdi_s,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sel_act,
  input  logic          sel_start,
  output logic          tx_take,
  output logic          bit_stb,
  output logic          bit_val,
  output logic          bit_first,
  output logic          byte_stb,
  output logic          busy,
  output logic          sclk_out,
  output logic          sdo
);
  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(DW);
  localparam logic [PW-1:0] PH_SMP   = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_HI    = PW'(HALF);
  localparam logic [PW-1:0] PH_END   = PW'(CLK_DIV - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic          busy_q, busy_n;
  logic [PW-1:0] ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] tsh_q, tsh_n;
  logic          skip_q, skip_n;
  logic [DW-1:0] reload;

  assign reload = tx_valid ? tx_data : '0;

  always_comb begin
    busy_n    = busy_q;
    ph_n      = ph_q;
    cnt_n     = cnt_q;
    tsh_n     = tsh_q;
    skip_n    = skip_q;
    tx_take   = 1'b0;
    bit_stb   = 1'b0;
    bit_val   = 1'b0;
    bit_first = 1'b0;
    byte_stb  = 1'b0;
    if (master) begin
      skip_n = 1'b0;
      if (!busy_q) begin
        if (tx_valid) begin
          busy_n  = 1'b1;
          tx_take = 1'b1;
          tsh_n   = tx_data;
          ph_n    = '0;
          cnt_n   = '0;
        end
      end else begin
        ph_n = ph_q + 1'b1;
        if (ph_q == PH_SMP) begin
          bit_stb   = 1'b1;
          bit_val   = sdi_m;
          bit_first = (cnt_q == '0);
          byte_stb  = (cnt_q == CNT_LAST);
        end
        if (ph_q == PH_END) begin
          ph_n = '0;
          if (cnt_q == CNT_LAST) begin
            busy_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
            tsh_n = {tsh_q[DW-2:0], 1'b0};
          end
        end
      end
    end else begin
      busy_n = 1'b0;
      ph_n   = '0;
      if (!sel_act) begin
        cnt_n  = '0;
        skip_n = 1'b0;
      end else if (sel_start) begin
        tsh_n   = reload;
        tx_take = tx_valid;
        cnt_n   = '0;
        skip_n  = 1'b0;
      end else if (sclk_rise) begin
        bit_stb   = 1'b1;
        bit_val   = sdi_s;
        bit_first = (cnt_q == '0);
        if (cnt_q == CNT_LAST) begin
          byte_stb = 1'b1;
          cnt_n    = '0;
          tsh_n    = reload;
          tx_take  = tx_valid;
          skip_n   = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (sclk_fall) begin
        if (skip_q) skip_n = 1'b0;
        else        tsh_n  = {tsh_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      cnt_q  <= '0;
      tsh_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      tsh_q  <= tsh_n;
      skip_q <= skip_n;
    end
  end

  assign busy     = busy_q;
  assign sclk_out = master & busy_q & (ph_q >= PH_HI);
  assign sdo      = tsh_q[DW-1];
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          bit_first,
  input  logic          byte_stb,
  input  logic          rd_rx,
  input  logic          clr_full,
  input  logic          clr_ovr,
  input  logic          ien_full,
  input  logic          ien_err,
  output logic [DW-1:0] rx_buf,
  output logic          rx_full,
  output logic          rx_hold,
  output logic          ovr,
  output logic          irq_full,
  output logic          irq_err
);
  logic [DW-1:0] sh_q, sh_n, buf_q, buf_n;
  logic          full_q, full_n, hold_q, hold_n, ovr_q, ovr_n;
  logic          set_full, set_err, irqf_q, irqe_q;

  always_comb begin
    sh_n     = bit_stb ? {sh_q[DW-2:0], bit_val} : sh_q;
    buf_n    = buf_q;
    full_n   = full_q;
    hold_n   = hold_q;
    ovr_n    = ovr_q;
    set_full = 1'b0;
    set_err  = 1'b0;
    if (rd_rx) begin
      if (hold_q) begin
        buf_n    = sh_q;
        full_n   = 1'b1;
        hold_n   = 1'b0;
        set_full = 1'b1;
      end else begin
        full_n = 1'b0;
      end
    end
    if (clr_full) full_n = 1'b0;
    if (clr_ovr)  ovr_n  = 1'b0;
    if (bit_stb && bit_first && hold_q) begin
      ovr_n   = 1'b1;
      set_err = 1'b1;
    end
    if (byte_stb) begin
      if (!full_n) begin
        buf_n    = sh_n;
        full_n   = 1'b1;
        hold_n   = 1'b0;
        set_full = 1'b1;
      end else begin
        hold_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      hold_q <= 1'b0;
      ovr_q  <= 1'b0;
      irqf_q <= 1'b0;
      irqe_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      buf_q  <= buf_n;
      full_q <= full_n;
      hold_q <= hold_n;
      ovr_q  <= ovr_n;
      irqf_q <= set_full & ien_full;
      irqe_q <= set_err & ien_err;
    end
  end

  assign rx_buf   = buf_q;
  assign rx_full  = full_q;
  assign rx_hold  = hold_q;
  assign ovr      = ovr_q;
  assign irq_full = irqf_q;
  assign irq_err  = irqe_q;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  input  logic              sel_n_in,
  input  logic              sdi,
  output logic              sclk_out,
  output logic              sdo,
  output logic              irq_rx_full,
  output logic              irq_rx_err
);
  localparam int PAD_W = DATA_W - 4;
  localparam int SYN_W = 3;
  localparam logic [SYN_W-1:0] SYN_RST = 3'b010;

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  assign rst_n_i = rst_s_q;

  // slave-side pins: {sdi, sel_n, sclk}
  logic [SYN_W-1:0] syn_q;
  spi_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d({sdi, sel_n_in, sclk_in}), .q(syn_q)
  );

  logic sclk_d_q, sel_act_d_q, sel_act;
  logic sclk_rise, sclk_fall, sel_start;
  assign sel_act   = ~syn_q[1];
  assign sclk_rise = syn_q[0] & ~sclk_d_q;
  assign sclk_fall = ~syn_q[0] & sclk_d_q;
  assign sel_start = sel_act & ~sel_act_d_q;

  // register decode
  logic wr_txd, wr_flag, wr_ien, rd_rxd;
  assign wr_txd  = reg_wr & (reg_addr == A_TXD);
  assign wr_flag = reg_wr & (reg_addr == A_FLAG);
  assign wr_ien  = reg_wr & (reg_addr == A_IEN);
  assign rd_rxd  = reg_rd & (reg_addr == A_RXD);

  logic [DATA_W-1:0] txd_q, txd_n;
  logic              txv_q, txv_n, txe_q, txe_n;
  logic [IEN_W-1:0]  ien_q, ien_n;

  logic tx_take, bit_stb, bit_val, bit_first, byte_stb, eng_busy;
  logic [DATA_W-1:0] rx_buf;
  logic rx_full, rx_hold, ovr_flag;

  spi_bit_engine #(.DW(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n_i), .master(mode_master),
    .tx_valid(txv_q), .tx_data(txd_q),
    .sdi_m(sdi), .sdi_s(syn_q[2]),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel_act(sel_act), .sel_start(sel_start),
    .tx_take(tx_take), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_first(bit_first), .byte_stb(byte_stb), .busy(eng_busy),
    .sclk_out(sclk_out), .sdo(sdo)
  );

  spi_rx_path #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n_i),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_first(bit_first),
    .byte_stb(byte_stb), .rd_rx(rd_rxd),
    .clr_full(wr_flag & reg_wdata[FB_RXF]),
    .clr_ovr(wr_flag & reg_wdata[FB_OVR]),
    .ien_full(ien_q[0]), .ien_err(ien_q[1]),
    .rx_buf(rx_buf), .rx_full(rx_full), .rx_hold(rx_hold), .ovr(ovr_flag),
    .irq_full(irq_rx_full), .irq_err(irq_rx_err)
  );

  always_comb begin
    txd_n = txd_q;
    txv_n = txv_q;
    txe_n = txe_q;
    ien_n = ien_q;
    if (tx_take) begin
      txv_n = 1'b0;
      txe_n = 1'b1;
    end
    if (wr_txd) begin
      txd_n = reg_wdata;
      txv_n = 1'b1;
      txe_n = 1'b0;
    end
    if (wr_flag && reg_wdata[FB_TXE]) txe_n = 1'b0;
    if (wr_ien) ien_n = reg_wdata[IEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      txd_q       <= '0;
      txv_q       <= 1'b0;
      txe_q       <= 1'b0;
      ien_q       <= '0;
      sclk_d_q    <= 1'b0;
      sel_act_d_q <= 1'b0;
    end else begin
      txd_q       <= txd_n;
      txv_q       <= txv_n;
      txe_q       <= txe_n;
      ien_q       <= ien_n;
      sclk_d_q    <= syn_q[0];
      sel_act_d_q <= sel_act;
    end
  end

  logic              stat_bit;
  logic [DATA_W-1:0] flags;
  assign stat_bit = mode_master ? eng_busy : syn_q[1];
  assign flags    = {{PAD_W{1'b0}}, stat_bit, ovr_flag, rx_full, txe_q};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_RXD:   reg_rdata = rx_buf;
        A_FLAG:  reg_rdata = flags;
        A_IEN:   reg_rdata = {{(DATA_W-IEN_W){1'b0}}, ien_q};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_master,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_rx_full,
  input logic       irq_rx_err,
  input logic       rx_full,
  input logic       rx_hold,
  input logic       ovr_flag,
  input logic       txe_q,
  input logic       eng_busy
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |-> (reg_rdata[7:4] == 4'h0)); // R1

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(mode_master)); // R2

  AST_TXE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $rose(eng_busy)) |-> txe_q); // R3

  AST_FULL_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |-> rx_full); // R4

  AST_OVR_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rx_hold)); // R6

  AST_ERR_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_err |-> ovr_flag); // R6

  AST_W0_KEEPS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !reg_wdata[2] && ovr_flag) |=> ovr_flag); // R7
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err),
  .rx_full(rx_full), .rx_hold(rx_hold), .ovr_flag(ovr_flag),
  .txe_q(txe_q), .eng_busy(eng_busy)
);

// File: tb/tb_spi_flag_ctrl.sv
module tb_spi_flag_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, mode_master, reg_wr, reg_rd, sclk_in, sel_n_in, s_sdi;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sdi, sclk_out, sdo, irq_rx_full, irq_rx_err;

  assign sdi = mode_master ? sdo : s_sdi;

  spi_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_in(sclk_in), .sel_n_in(sel_n_in), .sdi(sdi),
    .sclk_out(sclk_out), .sdo(sdo),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // every-clock monitor
  int cyc = 0, n_irq_full = 0, n_irq_err = 0, n_rise = 0, first_rise = 0, last_rise = 0;
  logic [7:0] wire_byte = 8'h00;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (irq_rx_full === 1'b1) n_irq_full++;
    if (irq_rx_err === 1'b1)  n_irq_err++;
    if (sclk_out === 1'b1 && sclk_prev === 1'b0) begin
      if (n_rise == 0) first_rise = cyc;
      last_rise = cyc;
      n_rise++;
      wire_byte = {wire_byte[6:0], sdo};
    end
    sclk_prev = sclk_out;
  end

  // behavioural reference model
  bit m_full = 0, m_hold = 0, m_ovf = 0, m_txe = 0, en_full = 0, en_err = 0;
  logic [7:0] m_buf = 8'h00;
  logic [7:0] held_q[$];
  int m_nf = 0, m_ne = 0;

  function automatic logic [7:0] ef(bit st);
    return {4'b0000, st, m_ovf, m_full, m_txe};
  endfunction

  task automatic model_first_bit();
    if (m_hold) begin m_ovf = 1; if (en_err) m_ne++; end
  endtask

  task automatic model_complete(logic [7:0] b);
    if (!m_full) begin
      m_buf = b; m_full = 1; m_hold = 0; held_q.delete();
      if (en_full) m_nf++;
    end else begin
      m_hold = 1; held_q.delete(); held_q.push_back(b);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic check_flags(string tag, bit st);
    logic [7:0] v;
    bus_read(2'd2, v);
    chk(tag, v, ef(st));
  endtask

  task automatic read_rx(string tag);
    logic [7:0] v, e;
    e = m_buf;
    if (m_hold) begin
      m_buf = held_q.pop_front(); m_full = 1; m_hold = 0;
      if (en_full) m_nf++;
    end else m_full = 0;
    bus_read(2'd1, v);
    chk(tag, v, e);
  endtask

  task automatic settle_irq(string tag);
    repeat (4) @(negedge clk);
    chk({tag, " full requests"}, n_irq_full, m_nf);
    chk({tag, " error requests"}, n_irq_err, m_ne);
  endtask

  task automatic master_xfer(logic [7:0] b);
    bus_write(2'd0, b);
    m_txe = 0;
    model_first_bit();
    repeat (40) @(negedge clk);
    m_txe = 1;
    model_complete(b);
  endtask

  task automatic s_sel(logic v);
    @(negedge clk); sel_n_in = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic s_bit(logic b, output logic o);
    s_sdi = b;
    repeat (8) @(negedge clk);
    o = sdo;
    sclk_in = 1'b1;
    repeat (8) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic s_byte(logic [7:0] b, output logic [7:0] cap);
    for (int i = 7; i >= 0; i--) begin
      logic o;
      s_bit(b[i], o);
      cap[i] = o;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, cap;
    rst_n = 0; mode_master = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    sclk_in = 0; sel_n_in = 1; s_sdi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state, R12 enable readback
    check_flags("R1 reset flags", 1'b0);
    chk("R12 rdata idle", reg_rdata, 8'h00);
    bus_read(2'd3, v); chk("R12 enables after reset", v, 8'h00);
    bus_write(2'd3, 8'h03); en_full = 1; en_err = 1;
    bus_read(2'd3, v); chk("R12 enables readback", v, 8'h03);

    // R2 busy, R3 load, R10 wire timing
    n_rise = 0;
    bus_write(2'd0, 8'hA5); m_txe = 0; model_first_bit();
    repeat (6) @(negedge clk);
    m_txe = 1;
    check_flags("R2 busy during transfer / R3 empty after load", 1'b1);
    repeat (40) @(negedge clk);
    model_complete(8'hA5);
    check_flags("R2 idle after transfer / R4 full", 1'b0);
    chk("R10 rising edge count", n_rise, 8);
    chk("R10 edge spacing", last_rise - first_rise, 28);
    chk("R10 MSB-first wire byte", wire_byte, 8'hA5);
    settle_irq("R4");
    read_rx("R12 rx data");
    check_flags("R5 read clears full", 1'b0);

    // R7 write-one-to-clear
    master_xfer(8'h5C);
    bus_write(2'd2, 8'h00);
    check_flags("R7 write zero no effect", 1'b0);
    bus_write(2'd2, 8'h02); m_full = 0;
    check_flags("R7 clear full", 1'b0);
    bus_write(2'd2, 8'h01); m_txe = 0;
    check_flags("R7 clear tx-empty", 1'b0);

    // R5 parked byte
    master_xfer(8'h11);
    master_xfer(8'h22);
    check_flags("R5 second byte parked, no overrun", 1'b0);
    read_rx("R5 first read returns older byte");
    check_flags("R5 full set again", 1'b0);
    settle_irq("R5 R4");
    read_rx("R5 second read returns parked byte");
    check_flags("R5 full cleared", 1'b0);

    // R6 overrun, R8 recovery write first
    master_xfer(8'h31);
    master_xfer(8'h32);
    master_xfer(8'h33);
    check_flags("R6 overrun set", 1'b0);
    settle_irq("R6");
    bus_write(2'd2, 8'h04); m_ovf = 0;
    read_rx("R8 first read");
    read_rx("R8 second read newest byte");
    check_flags("R8 recovered", 1'b0);

    // R13 disabled requests, R8 reverse order
    bus_write(2'd3, 8'h00); en_full = 0; en_err = 0;
    master_xfer(8'h41);
    master_xfer(8'h42);
    master_xfer(8'h43);
    settle_irq("R13");
    check_flags("R13 flags still set", 1'b0);
    read_rx("R8 reverse first read");
    read_rx("R8 reverse second read");
    check_flags("R8 overrun kept until acknowledged", 1'b0);
    bus_write(2'd2, 8'h04); m_ovf = 0;
    check_flags("R8 reverse recovered", 1'b0);

    // slave mode: R9, R3, R10, R11
    @(negedge clk); mode_master = 0;
    repeat (8) @(negedge clk);
    check_flags("R9 not selected reads 1", 1'b1);
    bus_write(2'd0, 8'h3C); m_txe = 0;
    check_flags("R3 write clears tx-empty", 1'b1);
    s_sel(1'b0); m_txe = 1;
    check_flags("R9 selected reads 0 / R3 load", 1'b0);
    model_first_bit();
    s_byte(8'hC3, cap);
    model_complete(8'hC3);
    chk("R10 slave output byte", cap, 8'h3C);
    s_sel(1'b1);
    check_flags("R4 slave byte received", 1'b1);
    read_rx("R4 slave rx data");

    s_sel(1'b0);
    for (int i = 0; i < 3; i++) begin
      logic o;
      s_bit(i[0], o);
    end
    s_sel(1'b1);
    check_flags("R11 partial byte discarded", 1'b1);
    s_sel(1'b0);
    model_first_bit();
    s_byte(8'h5A, cap);
    model_complete(8'h5A);
    s_sel(1'b1);
    read_rx("R11 whole byte after reselect");
    check_flags("R11 flags after read", 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule